// File: doc/BRIEF.md
# Branch Condition and Select Unit

This unit decides whether a 4-bit condition code holds against the status flags zero, sign, overflow and carry, plus a separate saturation flag. It uses the result in one of three ways. For a short conditional branch it sets the taken indication and computes the next program counter. For a conditional move it picks one of two operands. For a set-flag operation it produces the value 0 or 1.

One operation is accepted per cycle when `inValid` is high. All results are registered and appear one clock later with an `outValid` pulse. The branch displacement comes from two separate instruction fields. A 5-bit high field sits at bits 8..4 and a 3-bit low field at bits 3..1. Bit 0 is zero, so the displacement is always even, and it is sign-extended from bit 8. An always-true branch with both displacement fields zero is the breakpoint idiom. It does not branch and raises a trap request instead.

Top module: `brsel_unit`

## Requirements
- R1: While and after reset, until the first accepted operation, `outValid`, `taken` and `trapReq` are 0 and `nextPc` and `selValue` are all zeros.
- R2: Results of an operation accepted with `inValid`=1 appear on the clock edge that samples it. `outValid` is 1 for exactly that cycle. When `inValid`=0, `outValid` goes to 0 and `taken`, `trapReq`, `nextPc` and `selValue` hold their values. `opKind` encoding: 0 branch, 1 register conditional move, 2 immediate conditional move, 3 set-flag.
- R3: Codes 0..7 hold when the following is true: 0 OV; 1 CY; 2 Z; 3 CY or Z; 4 S; 5 always; 6 S xor OV; 7 (S xor OV) or Z.
- R4: Codes 8..15 hold when the code with bit 3 cleared does not hold. The exception is code 13 (0xD), which holds when the saturation flag is 1.
- R5: A branch whose condition holds (and that is not a trap, see R7) sets `taken`=1 and `nextPc` = pc + sign-extended {dispHi, dispLo, 0}, taken as a 9-bit field.
- R6: A branch whose condition fails sets `taken`=0 and `nextPc` = pc + 2.
- R7: A branch with code 5 and both displacement fields zero sets `trapReq`=1, `taken`=0 and `nextPc` = pc. Any other code or displacement gives `trapReq`=0.
- R8: A register conditional move outputs `opA` when the condition holds and `opB` otherwise.
- R9: An immediate conditional move uses the 5-bit immediate, sign-extended to 32 bits, in place of `opA`.
- R10: A set-flag operation outputs 1 when the condition holds and 0 otherwise.
- R11: Non-branch operations never trap or take, and give `nextPc` = pc + 2, even with code 5 and zero displacement fields. A branch operation outputs `selValue` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Accept an operation this cycle |
| opKind | input | 2 | Operation kind (see R2) |
| condCode | input | 4 | Condition code |
| flagZ | input | 1 | Zero flag |
| flagS | input | 1 | Sign flag |
| flagOv | input | 1 | Overflow flag |
| flagCy | input | 1 | Carry flag |
| flagSat | input | 1 | Saturation flag |
| pcIn | input | 32 | Address of the operation |
| dispHi | input | 5 | High displacement field (bits 8..4) |
| dispLo | input | 3 | Low displacement field (bits 3..1) |
| opA | input | 32 | Operand chosen when the condition holds |
| opB | input | 32 | Operand chosen when the condition fails |
| imm5 | input | 5 | Immediate for the immediate move form |
| outValid | output | 1 | Registered results are new this cycle |
| taken | output | 1 | Branch taken |
| nextPc | output | 32 | Next program counter |
| selValue | output | 32 | Move or set-flag result |
| trapReq | output | 1 | Breakpoint trap request |

## Verification
The bench sweeps all sixteen codes against every combination of the five flags. A swapped or uninverted code therefore shows up as a wrong 0/1 result. Branches are driven with forward, minus-two and most-negative displacements. A design that drops the sign extension, misplaces one of the two fields or forgets the implied zero bit lands on the wrong address. The trap idiom is tried as a branch, with an always-true code and non-zero displacement, with the saturated code and zero displacement, and as a set-flag operation. A design that decodes it too loosely or too tightly either traps when it should not or branches to itself. Idle cycles with changing inputs catch outputs that fail to hold.

// File: rtl/brsel_pkg.sv
package brsel_pkg;

  typedef enum logic [1:0] {
    OP_BRANCH   = 2'd0,
    OP_CMOV_REG = 2'd1,
    OP_CMOV_IMM = 2'd2,
    OP_SET_FLAG = 2'd3
  } opKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic isBranch;
    logic takeBranch;
    logic raiseTrap;
    logic pickA;
    logic useImm;
    logic isFlagOp;
    logic condBit;
  } ctrlStrobes_t;

  localparam logic [3:0] CODE_ALWAYS = 4'h5;
  localparam logic [3:0] CODE_SAT    = 4'hD;

endpackage

// File: rtl/brsel_ctrl.sv
module brsel_ctrl
  import brsel_pkg::*;
#(
  parameter int HI_W = 5,
  parameter int LO_W = 3
) (
  input  logic              inValid,
  input  logic [1:0]        opKind,
  input  logic [3:0]        condCode,
  input  logic              flagZ,
  input  logic              flagS,
  input  logic              flagOv,
  input  logic              flagCy,
  input  logic              flagSat,
  input  logic [HI_W-1:0]   dispHi,
  input  logic [LO_W-1:0]   dispLo,
  output ctrlStrobes_t      strobes
);

  logic baseMet;
  logic condMet;
  logic dispIsZero;
  logic isBranchOp;
  logic trapHit;
  opKind_e kind;

  assign kind = opKind_e'(opKind);

  always_comb begin
    unique case (condCode[2:0])
      3'd0: baseMet = flagOv;
      3'd1: baseMet = flagCy;
      3'd2: baseMet = flagZ;
      3'd3: baseMet = flagCy | flagZ;
      3'd4: baseMet = flagS;
      3'd5: baseMet = 1'b1;
      3'd6: baseMet = flagS ^ flagOv;
      default: baseMet = (flagS ^ flagOv) | flagZ;
    endcase
  end

  always_comb begin
    if (condCode == CODE_SAT) condMet = flagSat;
    else if (condCode[3])     condMet = ~baseMet;
    else                      condMet = baseMet;
  end

  assign dispIsZero = ~|{dispHi, dispLo};
  assign isBranchOp = (kind == OP_BRANCH);
  assign trapHit    = isBranchOp && (condCode == CODE_ALWAYS) && dispIsZero;

  always_comb begin
    strobes.load       = inValid;
    strobes.isBranch   = isBranchOp;
    strobes.raiseTrap  = trapHit;
    strobes.takeBranch = isBranchOp && condMet && !trapHit;
    strobes.pickA      = condMet;
    strobes.useImm     = (kind == OP_CMOV_IMM);
    strobes.isFlagOp   = (kind == OP_SET_FLAG);
    strobes.condBit    = condMet;
  end

endmodule

// File: rtl/brsel_dp.sv
module brsel_dp
  import brsel_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  parameter int HI_W   = 5,
  parameter int LO_W   = 3,
  parameter int IMM_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [HI_W-1:0]   dispHi,
  input  logic [LO_W-1:0]   dispLo,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  imm5,
  output logic              outValid,
  output logic              taken,
  output logic [PC_W-1:0]   nextPc,
  output logic [DATA_W-1:0] selValue,
  output logic              trapReq
);

  localparam int DISP_W = HI_W + LO_W + 1;
  localparam logic [PC_W-1:0] STEP = PC_W'(2);

  logic [DISP_W-1:0] dispRaw;
  logic [PC_W-1:0]   dispExt;
  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] moveSrcA;
  logic [PC_W-1:0]   nextPcD;
  logic [DATA_W-1:0] selD;

  assign dispRaw = {dispHi, dispLo, 1'b0};

  generate
    if (PC_W > DISP_W) begin : g_dispWide
      assign dispExt = {{(PC_W-DISP_W){dispRaw[DISP_W-1]}}, dispRaw};
    end else begin : g_dispNarrow
      assign dispExt = dispRaw[PC_W-1:0];
    end
    if (DATA_W > IMM_W) begin : g_immWide
      assign immExt = {{(DATA_W-IMM_W){imm5[IMM_W-1]}}, imm5};
    end else begin : g_immNarrow
      assign immExt = imm5[DATA_W-1:0];
    end
  endgenerate

  assign moveSrcA = strobes.useImm ? immExt : opA;

  always_comb begin
    if (strobes.raiseTrap)       nextPcD = pcIn;
    else if (strobes.takeBranch) nextPcD = pcIn + dispExt;
    else                         nextPcD = pcIn + STEP;
  end

  always_comb begin
    if (strobes.isFlagOp)      selD = {{(DATA_W-1){1'b0}}, strobes.condBit};
    else if (strobes.isBranch) selD = '0;
    else if (strobes.pickA)    selD = moveSrcA;
    else                       selD = opB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      taken    <= 1'b0;
      trapReq  <= 1'b0;
      nextPc   <= '0;
      selValue <= '0;
    end else begin
      outValid <= strobes.load;
      if (strobes.load) begin
        taken    <= strobes.takeBranch;
        trapReq  <= strobes.raiseTrap;
        nextPc   <= nextPcD;
        selValue <= selD;
      end
    end
  end

endmodule

// File: rtl/brsel_unit.sv
module brsel_unit
  import brsel_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PC_W   = 32,
  parameter int HI_W   = 5,
  parameter int LO_W   = 3,
  parameter int IMM_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        opKind,
  input  logic [3:0]        condCode,
  input  logic              flagZ,
  input  logic              flagS,
  input  logic              flagOv,
  input  logic              flagCy,
  input  logic              flagSat,
  input  logic [PC_W-1:0]   pcIn,
  input  logic [HI_W-1:0]   dispHi,
  input  logic [LO_W-1:0]   dispLo,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  imm5,
  output logic              outValid,
  output logic              taken,
  output logic [PC_W-1:0]   nextPc,
  output logic [DATA_W-1:0] selValue,
  output logic              trapReq
);

  ctrlStrobes_t strobes;

  brsel_ctrl #(.HI_W(HI_W), .LO_W(LO_W)) u_ctrl (
    .inValid (inValid),
    .opKind  (opKind),
    .condCode(condCode),
    .flagZ   (flagZ),
    .flagS   (flagS),
    .flagOv  (flagOv),
    .flagCy  (flagCy),
    .flagSat (flagSat),
    .dispHi  (dispHi),
    .dispLo  (dispLo),
    .strobes (strobes)
  );

  brsel_dp #(
    .DATA_W(DATA_W), .PC_W(PC_W), .HI_W(HI_W), .LO_W(LO_W), .IMM_W(IMM_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .pcIn    (pcIn),
    .dispHi  (dispHi),
    .dispLo  (dispLo),
    .opA     (opA),
    .opB     (opB),
    .imm5    (imm5),
    .outValid(outValid),
    .taken   (taken),
    .nextPc  (nextPc),
    .selValue(selValue),
    .trapReq (trapReq)
  );

endmodule

// File: rtl/brsel_chk.sv
module brsel_chk #(
  parameter int DATA_W = 32,
  parameter int PC_W   = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [1:0]        opKind,
  input logic [PC_W-1:0]   pcIn,
  input logic              outValid,
  input logic              taken,
  input logic [PC_W-1:0]   nextPc,
  input logic [DATA_W-1:0] selValue,
  input logic              trapReq
);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (outValid == $past(inValid)));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(inValid)) |-> ($stable(nextPc) && $stable(selValue) && $stable(taken)));

  // R7
  trap_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(taken && trapReq));

  // R5
  taken_kind_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && taken) |-> ($past(opKind) == 2'd0));

  // R11
  nonbranch_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && $past(opKind) != 2'd0)
      |-> (nextPc == $past(pcIn) + PC_W'(2) && !taken && !trapReq));

  // R10
  flag_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid) && $past(opKind) == 2'd3)
      |-> (selValue[DATA_W-1:1] == '0));

  // R5
  pc_parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(inValid)) |-> (nextPc[0] == $past(pcIn[0])));

endmodule

bind brsel_unit brsel_chk #(.DATA_W(DATA_W), .PC_W(PC_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .opKind  (opKind),
  .pcIn    (pcIn),
  .outValid(outValid),
  .taken   (taken),
  .nextPc  (nextPc),
  .selValue(selValue),
  .trapReq (trapReq)
);

// File: tb/tb_brsel_unit.sv
module tb_brsel_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  opKind = '0;
  logic [3:0]  condCode = '0;
  logic        flagZ = 0, flagS = 0, flagOv = 0, flagCy = 0, flagSat = 0;
  logic [31:0] pcIn = '0;
  logic [4:0]  dispHi = '0;
  logic [2:0]  dispLo = '0;
  logic [31:0] opA = '0, opB = '0;
  logic [4:0]  imm5 = '0;
  logic        outValid, taken, trapReq;
  logic [31:0] nextPc, selValue;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brsel_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opKind(opKind),
    .condCode(condCode), .flagZ(flagZ), .flagS(flagS), .flagOv(flagOv),
    .flagCy(flagCy), .flagSat(flagSat), .pcIn(pcIn), .dispHi(dispHi),
    .dispLo(dispLo), .opA(opA), .opB(opB), .imm5(imm5),
    .outValid(outValid), .taken(taken), .nextPc(nextPc),
    .selValue(selValue), .trapReq(trapReq)
  );

  function automatic bit condRef(input logic [3:0] c, input logic z, s, ov, cy, sat);
    case (c)
      4'h0: return ov;
      4'h1: return cy;
      4'h2: return z;
      4'h3: return cy | z;
      4'h4: return s;
      4'h5: return 1'b1;
      4'h6: return s ^ ov;
      4'h7: return (s ^ ov) | z;
      4'h8: return !ov;
      4'h9: return !cy;
      4'hA: return !z;
      4'hB: return !(cy | z);
      4'hC: return !s;
      4'hD: return sat;
      4'hE: return !(s ^ ov);
      default: return !((s ^ ov) | z);
    endcase
  endfunction

  function automatic logic [31:0] dispRef(input logic [4:0] hi, input logic [2:0] lo);
    logic [31:0] v;
    v = 32'(hi) * 16 + 32'(lo) * 2;
    if (hi[4]) v = v - 32'd512;
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic [3:0] c, input logic [4:0] fl,
                       input logic [31:0] pc, input logic [4:0] hi, input logic [2:0] lo,
                       input logic [31:0] a, input logic [31:0] b, input logic [4:0] im);
    @(negedge clk);
    inValid = 1'b1; opKind = k; condCode = c;
    {flagSat, flagZ, flagS, flagOv, flagCy} = fl;
    pcIn = pc; dispHi = hi; dispLo = lo; opA = a; opB = b; imm5 = im;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic test_reset();
    check("R1 outValid", 32'(outValid), 0);
    check("R1 taken", 32'(taken), 0);
    check("R1 trapReq", 32'(trapReq), 0);
    check("R1 nextPc", nextPc, 0);
    check("R1 selValue", selValue, 0);
  endtask

  task automatic test_conditions();
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 32; f++) begin
        logic [4:0] fl;
        fl = 5'(f);
        issue(2'd3, 4'(c), fl, 32'h400, 0, 0, 0, 0, 0);
        check(c < 8 ? "R3 cond" : "R4 cond", selValue,
              32'(condRef(4'(c), fl[3], fl[2], fl[1], fl[0], fl[4])));
      end
    end
    check("R10 outValid", 32'(outValid), 1);
  endtask

  task automatic test_branch();
    // fl bit order {sat,z,s,ov,cy}
    issue(2'd0, 4'h2, 5'b01000, 32'h1000, 5'h03, 3'h5, 0, 0, 0);
    check("R5 taken", 32'(taken), 1);
    check("R5 fwd", nextPc, 32'h1000 + dispRef(5'h03, 3'h5));
    check("R5 fwd literal", nextPc, 32'h103A);
    check("R11 branch sel", selValue, 0);
    issue(2'd0, 4'h5, 5'b0, 32'h2000, 5'h1F, 3'h7, 0, 0, 0);
    check("R5 minus2", nextPc, 32'h1FFE);
    issue(2'd0, 4'h5, 5'b0, 32'h3000, 5'h10, 3'h0, 0, 0, 0);
    check("R5 min", nextPc, 32'h2F00);
    issue(2'd0, 4'h5, 5'b0, 32'h3000, 5'h00, 3'h1, 0, 0, 0);
    check("R5 always small", nextPc, 32'h3002);
    check("R7 no trap", 32'(trapReq), 0);
    issue(2'd0, 4'h2, 5'b00000, 32'h1000, 5'h03, 3'h5, 0, 0, 0);
    check("R6 taken", 32'(taken), 0);
    check("R6 seq", nextPc, 32'h1002);
  endtask

  task automatic test_trap();
    issue(2'd0, 4'h5, 5'b0, 32'h5554, 0, 0, 0, 0, 0);
    check("R7 trap", 32'(trapReq), 1);
    check("R7 taken", 32'(taken), 0);
    check("R7 pc", nextPc, 32'h5554);
    issue(2'd0, 4'hD, 5'b10000, 32'h5554, 0, 0, 0, 0, 0);
    check("R7 sat trap", 32'(trapReq), 0);
    check("R7 sat taken", 32'(taken), 1);
    check("R7 sat pc", nextPc, 32'h5554);
    issue(2'd3, 4'h5, 5'b0, 32'h5554, 0, 0, 0, 0, 0);
    check("R11 flag trap", 32'(trapReq), 0);
    check("R11 flag pc", nextPc, 32'h5556);
    check("R11 flag val", selValue, 1);
  endtask

  task automatic test_cmov();
    issue(2'd1, 4'h2, 5'b01000, 32'h80, 0, 0, 32'hAAAA5555, 32'h12345678, 0);
    check("R8 true", selValue, 32'hAAAA5555);
    issue(2'd1, 4'h2, 5'b00000, 32'h80, 0, 0, 32'hAAAA5555, 32'h12345678, 0);
    check("R8 false", selValue, 32'h12345678);
    issue(2'd1, 4'h5, 5'b0, 32'h80, 0, 0, 32'h1, 32'h2, 0);
    check("R11 cmov taken", 32'(taken), 0);
    check("R11 cmov trap", 32'(trapReq), 0);
    check("R11 cmov pc", nextPc, 32'h82);
    issue(2'd2, 4'h5, 5'b0, 32'h90, 0, 0, 32'h1, 32'h2, 5'h1F);
    check("R9 neg imm", selValue, 32'hFFFFFFFF);
    issue(2'd2, 4'h1, 5'b00001, 32'h90, 0, 0, 32'h1, 32'h2, 5'h0F);
    check("R9 pos imm", selValue, 32'h0000000F);
    issue(2'd2, 4'h1, 5'b00000, 32'h90, 0, 0, 32'h1, 32'h2, 5'h0F);
    check("R9 false", selValue, 32'h2);
  endtask

  task automatic test_hold();
    issue(2'd0, 4'h5, 5'b0, 32'h7000, 5'h01, 3'h0, 0, 0, 0);
    check("R2 valid pulse", 32'(outValid), 1);
    check("R2 taken", 32'(taken), 1);
    opKind = 2'd1; condCode = 4'h5; pcIn = 32'hDEAD0000; opA = 32'h99; dispHi = 0;
    @(negedge clk);
    @(negedge clk);
    check("R2 valid low", 32'(outValid), 0);
    check("R2 hold pc", nextPc, 32'h7010);
    check("R2 hold taken", 32'(taken), 1);
    check("R2 hold sel", selValue, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_branch();
    test_trap();
    test_cmov();
    test_hold();
    test_conditions();
    finish_run();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

endmodule